// File: doc/BRIEF.md
# Overcurrent Timed Latch-Off Controller

This block supervises one or more power-switch channels. Each channel is digital only. It takes an enable request, a comparator flag that reports overcurrent, and a shared flag that reports the supply is above its undervoltage threshold. From these it drives four things: the switch gate request, a flag that puts the analog loop into current regulation, a select between a fast and a soft ramp-down, and an active-low fault line.

When overcurrent appears on a running channel, a timer of fixed length starts. If the overcurrent goes away first, the channel returns to normal. If it is still present when the timer expires, the switch is latched off and the fault line goes low. The fault line stays low until enable is removed. Fault reporting is suppressed during a blanking window that follows each turn-on. Channels share only the clock, the reset and the supply flag, so a fault on one channel does not disturb any other. Two channels make a dual-port controller.

Top module: `ocp_latchoff_ctrl`

## Requirements
- R1: When enable becomes active on a channel in the off state, that channel turns its switch on after one clock. It stays in the blanking state for BLANK_CYCLES clocks and then moves to the normal on state.
- R2: When a channel is in the on state, a rising overcurrent input takes it into regulation on the third clock edge after the change, because the input passes through a two-flop synchronizer. While in regulation, `regulating` is 1 and the switch stays on.
- R3: When overcurrent remains present for LATCH_CYCLES clocks in regulation, the channel latches off: `sw_on` goes to 0 and `fault_n` goes to 0.
- R4: While a channel is latched and its enable stays active, the channel stays latched and `fault_n` stays at a constant 0 on every clock, whatever the overcurrent input does.
- R5: Deactivating enable on a latched channel moves it to off on the next clock and returns `fault_n` to 1. A later enable begins a new turn-on.
- R6: When overcurrent clears before the timer expires, the channel returns to the on state. The next overcurrent starts a full LATCH_CYCLES period from zero.
- R7: Overcurrent during blanking neither enters regulation nor reports a fault. If overcurrent is still present when blanking ends, the channel enters regulation and latches off after LATCH_CYCLES.
- R8: `fast_off` becomes 1 at latch-off and stays 1 until the next turn-on. A normal disable from the on state leaves `fast_off` at 0, which selects the soft ramp.
- R9: When the synchronized supply flag is low, every channel goes to off on the third clock edge after the input falls, with `fault_n` released to 1. Enable is ignored until the flag returns.
- R10: A channel's overcurrent, timer or latch never changes the state or outputs of another channel.
- R11: EN_ACTIVE_HIGH=1 treats en_in=1 as the enable request, and EN_ACTIVE_HIGH=0 treats en_in=0 as the enable request.
- R12: Reset (active-low, synchronous) puts every channel in off, with `sw_on`=0, `regulating`=0, `fast_off`=0 and `fault_n`=1. `state_o[3i+2:3i]` carries channel i's state, coded off=0, blanking=1, on=2, regulation=3, latched=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | NCH | Per-channel enable request, polarity set by EN_ACTIVE_HIGH |
| oc_raw | input | NCH | Per-channel overcurrent comparator flag, asynchronous |
| uv_ok_raw | input | 1 | Supply above undervoltage threshold, asynchronous |
| sw_on | output | NCH | Switch gate request |
| regulating | output | NCH | Current-regulation mode flag |
| fast_off | output | NCH | 1 selects fast pull-down, 0 selects soft ramp |
| fault_n | output | NCH | Active-low latched fault, 1 means released |
| state_o | output | 3*NCH | Per-channel state code |

## Verification
The assertions assume that `en_in` is already synchronous to `clk`. Only the overcurrent and supply flags get synchronizers. The assertions also assume that reset is held for at least one edge before any property is checked. The bench changes every input on the falling clock edge, so `en_in` always meets setup. It also holds reset low over several edges before releasing it. The bench never changes the overcurrent flag faster than once per clock, which keeps the synchronizer latency at exactly two edges and allows the expected cycle counts to be exact.

// File: rtl/ocp_latchoff_ctrl.sv
module ocp_latchoff_ctrl #(
  parameter int NCH            = 2,
  parameter int LATCH_CYCLES   = 600000,
  parameter int BLANK_CYCLES   = 600000,
  parameter bit EN_ACTIVE_HIGH = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH-1:0]     en_in,
  input  logic [NCH-1:0]     oc_raw,
  input  logic               uv_ok_raw,
  output logic [NCH-1:0]     sw_on,
  output logic [NCH-1:0]     regulating,
  output logic [NCH-1:0]     fast_off,
  output logic [NCH-1:0]     fault_n,
  output logic [3*NCH-1:0]   state_o
);

  localparam int TMAX = (LATCH_CYCLES > BLANK_CYCLES) ? LATCH_CYCLES : BLANK_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] LAT_END = TW'(LATCH_CYCLES - 1);
  localparam logic [TW-1:0] BLK_END = TW'(BLANK_CYCLES - 1);

  localparam logic [2:0] S_OFF   = 3'd0;
  localparam logic [2:0] S_BLANK = 3'd1;
  localparam logic [2:0] S_ON    = 3'd2;
  localparam logic [2:0] S_REG   = 3'd3;
  localparam logic [2:0] S_LATCH = 3'd4;

  logic [1:0]     uv_q;
  logic           uv_ok;
  logic [NCH-1:0] en_act;

  always_ff @(posedge clk) begin
    if (!rst_n) uv_q <= 2'b00;
    else        uv_q <= {uv_q[0], uv_ok_raw};
  end

  assign uv_ok  = uv_q[1];
  assign en_act = EN_ACTIVE_HIGH ? en_in : ~en_in;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0]    oc_q;
    logic          oc;
    logic [2:0]    st, st_nx;
    logic [TW-1:0] tmr, tmr_nx;
    logic          fast_q;

    assign oc = oc_q[1];

    always_comb begin
      st_nx  = st;
      tmr_nx = tmr;
      if (!uv_ok) begin
        st_nx  = S_OFF;
        tmr_nx = '0;
      end else begin
        case (st)
          S_OFF:
            if (en_act[i]) begin
              st_nx  = S_BLANK;
              tmr_nx = '0;
            end
          S_BLANK:
            if (!en_act[i]) st_nx = S_OFF;
            else if (tmr == BLK_END) begin
              st_nx  = oc ? S_REG : S_ON;
              tmr_nx = '0;
            end else tmr_nx = tmr + 1'b1;
          S_ON:
            if (!en_act[i]) st_nx = S_OFF;
            else if (oc) begin
              st_nx  = S_REG;
              tmr_nx = '0;
            end
          S_REG:
            if (!en_act[i]) st_nx = S_OFF;
            else if (!oc) begin
              st_nx  = S_ON;
              tmr_nx = '0;
            end else if (tmr == LAT_END) begin
              st_nx  = S_LATCH;
              tmr_nx = '0;
            end else tmr_nx = tmr + 1'b1;
          S_LATCH:
            if (!en_act[i]) st_nx = S_OFF;
          default: st_nx = S_OFF;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        oc_q   <= 2'b00;
        st     <= S_OFF;
        tmr    <= '0;
        fast_q <= 1'b0;
      end else begin
        oc_q <= {oc_q[0], oc_raw[i]};
        st   <= st_nx;
        tmr  <= tmr_nx;
        if (!uv_ok || st_nx == S_BLANK) fast_q <= 1'b0;
        else if (st == S_REG && st_nx == S_LATCH) fast_q <= 1'b1;
      end
    end

    assign sw_on[i]          = (st == S_BLANK) || (st == S_ON) || (st == S_REG);
    assign regulating[i]     = (st == S_REG);
    assign fault_n[i]        = (st != S_LATCH);
    assign fast_off[i]       = fast_q;
    assign state_o[3*i +: 3] = st;

    a_r3_latch_only_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LATCH && $past(st) != S_LATCH) |-> ($past(st) == S_REG && $past(oc)));

    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LATCH && en_act[i] && uv_ok) |=> (st == S_LATCH && !fault_n[i]));

    a_r6_reg_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_REG && uv_ok && en_act[i] && !oc) |=> (st == S_ON));

    a_r7_blank_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BLANK) |=> (st != S_LATCH && fault_n[i]));

    a_r8_fast_at_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_LATCH) |-> fast_off[i]);

    a_r9_uv_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!uv_ok) |=> (st == S_OFF && fault_n[i] && !sw_on[i]));
  end

endmodule

// File: tb/tb_ocp_latchoff_ctrl.sv
module tb_ocp_latchoff_ctrl;
  localparam int L = 20;
  localparam int B = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] en, oc;
  logic       uv;
  logic [1:0] sw_on, regulating, fast_off, fault_n;
  logic [5:0] state_o;
  logic       al_en, al_oc;
  logic       al_sw, al_reg, al_fast, al_fault;
  logic [2:0] al_state;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #10 clk = ~clk;

  ocp_latchoff_ctrl #(.NCH(2), .LATCH_CYCLES(L), .BLANK_CYCLES(B), .EN_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en_in(en), .oc_raw(oc), .uv_ok_raw(uv),
    .sw_on(sw_on), .regulating(regulating), .fast_off(fast_off), .fault_n(fault_n),
    .state_o(state_o));

  ocp_latchoff_ctrl #(.NCH(1), .LATCH_CYCLES(L), .BLANK_CYCLES(B), .EN_ACTIVE_HIGH(1'b0)) dut_al (
    .clk(clk), .rst_n(rst_n), .en_in(al_en), .oc_raw(al_oc), .uv_ok_raw(uv),
    .sw_on(al_sw), .regulating(al_reg), .fast_off(al_fast), .fault_n(al_fault),
    .state_o(al_state));

  function automatic int stc(int ch);
    return int'(state_o[3*ch +: 3]);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset;
    tick(3);
    chk("R12", "st0", stc(0), 0);
    chk("R12", "st1", stc(1), 0);
    chk("R12", "sw_on", int'(sw_on), 0);
    chk("R12", "fault_n", int'(fault_n), 3);
    chk("R12", "fast/reg", int'({fast_off, regulating}), 0);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic t_polarity;
    chk("R11", "al idle off", int'(al_state), 0);
    chk("R11", "high-pol idle off", stc(0), 0);
    al_en = 1'b0;
    tick(1);
    chk("R11", "al low enables", int'(al_state), 1);
    al_en = 1'b1;
    tick(1);
    chk("R11", "al high disables", int'(al_state), 0);
  endtask

  task automatic t_turn_on;
    en = 2'b11;
    tick(1);
    chk("R1", "st0 blank", stc(0), 1);
    chk("R1", "sw_on0", int'(sw_on[0]), 1);
    chk("R1", "st1 blank", stc(1), 1);
    tick(B - 1);
    chk("R1", "st0 still blank", stc(0), 1);
    tick(1);
    chk("R1", "st0 on", stc(0), 2);
    chk("R1", "st1 on", stc(1), 2);
  endtask

  task automatic t_oc_recover_latch;
    oc[0] = 1'b1;
    tick(2);
    chk("R2", "sync delay", stc(0), 2);
    tick(1);
    chk("R2", "reg", stc(0), 3);
    chk("R2", "regulating", int'(regulating[0]), 1);
    chk("R2", "sw stays on", int'(sw_on[0]), 1);
    tick(5);
    oc[0] = 1'b0;
    tick(3);
    chk("R6", "back on", stc(0), 2);
    chk("R6", "reg flag off", int'(regulating[0]), 0);
    oc[0] = 1'b1;
    tick(3);
    chk("R6", "reg again", stc(0), 3);
    tick(L - 1);
    chk("R6", "full period restarted", stc(0), 3);
    tick(1);
    chk("R3", "latched", stc(0), 4);
    chk("R3", "sw off", int'(sw_on[0]), 0);
    chk("R3", "fault low", int'(fault_n[0]), 0);
    chk("R8", "fast on latch", int'(fast_off[0]), 1);
    chk("R10", "ch1 on", stc(1), 2);
    chk("R10", "ch1 fault released", int'(fault_n[1]), 1);
  endtask

  task automatic t_latched_hold;
    int misses = 0;
    for (int k = 0; k < 12; k++) begin
      oc[0] = ~oc[0];
      tick(1);
      if (fault_n[0] !== 1'b0 || stc(0) != 4) misses++;
    end
    chk("R4", "steady low fault cycles missed", misses, 0);
    oc[0] = 1'b0;
    tick(3);
    chk("R4", "still latched oc gone", stc(0), 4);
  endtask

  task automatic t_clear;
    en[0] = 1'b0;
    tick(1);
    chk("R5", "off after disable", stc(0), 0);
    chk("R5", "fault released", int'(fault_n[0]), 1);
    chk("R8", "fast held while off", int'(fast_off[0]), 1);
    en[0] = 1'b1;
    tick(1);
    chk("R5", "fresh blank", stc(0), 1);
    chk("R8", "fast cleared at turn-on", int'(fast_off[0]), 0);
    tick(B);
    chk("R5", "on again", stc(0), 2);
    en[0] = 1'b0;
    tick(1);
    chk("R8", "normal disable off", stc(0), 0);
    chk("R8", "soft ramp", int'(fast_off[0]), 0);
  endtask

  task automatic t_blank_oc;
    int bad_cyc = 0;
    oc[0] = 1'b1;
    en[0] = 1'b1;
    tick(1);
    chk("R7", "blank", stc(0), 1);
    for (int k = 0; k < B - 1; k++) begin
      tick(1);
      if (stc(0) != 1 || fault_n[0] !== 1'b1) bad_cyc++;
    end
    chk("R7", "cycles out of blank", bad_cyc, 0);
    tick(1);
    chk("R7", "reg after blank", stc(0), 3);
    tick(L - 1);
    chk("R7", "still reg", stc(0), 3);
    tick(1);
    chk("R7", "latched", stc(0), 4);
  endtask

  task automatic t_uv;
    uv = 1'b0;
    tick(3);
    chk("R9", "ch0 off", stc(0), 0);
    chk("R9", "ch0 fault released", int'(fault_n[0]), 1);
    chk("R9", "ch1 off", stc(1), 0);
    chk("R9", "sw off", int'(sw_on), 0);
    tick(5);
    chk("R9", "enable ignored", stc(0), 0);
    oc[0] = 1'b0;
    uv = 1'b1;
    tick(2);
    chk("R9", "still off in sync", stc(0), 0);
    tick(1);
    chk("R9", "restart blank", stc(0), 1);
    chk("R9", "ch1 restart blank", stc(1), 1);
  endtask

  initial begin
    rst_n = 1'b0; en = 2'b00; oc = 2'b00; uv = 1'b1;
    al_en = 1'b1; al_oc = 1'b0;
    t_reset();
    t_polarity();
    t_turn_on();
    t_oc_recover_latch();
    t_latched_hold();
    t_clear();
    t_blank_oc();
    t_uv();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule